// File: doc/BRIEF.md
# Sliding-Window Pairwise Difference Engine

This block receives a stream of prediction errors together with the matching input samples, at most one pair per clock. It keeps every earlier value of the current window in a history register. When a new pair arrives, the block subtracts each stored error from the new error, and each stored sample from the new sample. All of these subtractions happen in parallel in the same cycle. One clock later, the differences leave on two wide lane buses, with a per-lane valid mask and a strobe.

The window holds `WIN_LEN` slots. Over those slots the full triangle of roughly `WIN_LEN²/2` pairwise distances builds up, so the quadratic workload is spread over the arrival of the data instead of running as a nested loop. With the window's last slot the block raises a done pulse and wipes the history, and the next accepted pair opens a fresh window. A later stage evaluates a kernel on each error difference and weights it by the matching sample difference. That stage consumes the lane buses directly.

Arithmetic is 32-bit two's-complement fixed point by default. In the default mode a difference that leaves the signed range is clamped, and the clamp is recorded in a sticky flag.

Top module: `pairdiff_window`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_lane_valid`, `out_ediff`, `out_xdiff`, `window_done` and `ovf_sticky` are all zero. The first pair accepted after reset occupies slot 0 of a new window, even if the reset arrived mid-window.
- R2: The pair accepted in slot k (0-based, k from 0 to WIN_LEN-1) gives, on the next cycle, `out_valid`=1 and `out_lane_valid` equal to (1<<k)-1. Lanes 0 to k-1 are set and the rest are clear, so the top lane WIN_LEN-1 is never set.
- R3: For a valid lane j, `out_ediff[j]` equals the new error minus the error accepted j+1 pairs earlier in the same window. `out_xdiff[j]` is the same difference taken on the samples.
- R4: Every lane whose `out_lane_valid` bit is clear carries zero on both `out_ediff` and `out_xdiff`.
- R5: With the default clamping mode, a difference above 2^31-1 is output as 0x7FFFFFFF and a difference below -2^31 is output as 0x80000000.
- R6: `ovf_sticky` rises on the output cycle of any valid lane whose error or sample difference needed clamping. It stays high until reset.
- R7: `window_done` is high exactly on the output cycle of the slot WIN_LEN-1 pair. The next accepted pair starts a new window in slot 0 and shows an all-zero lane mask.
- R8: A cycle with `in_valid` low gives `out_valid`=0, a zero lane mask and `window_done`=0 on the next cycle. It leaves the history and the slot position untouched, whatever values sit on the data inputs.
- R9: The parameters are checked at elaboration: `WIN_LEN` must be at least 2 and `DW` at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_error` and `in_x` this cycle |
| in_error | input | DW | New prediction error, signed |
| in_x | input | DW | New input sample, signed |
| out_valid | output | 1 | Difference set present this cycle |
| out_lane_valid | output | WIN_LEN | Per-lane valid mask |
| out_ediff | output | WIN_LEN×DW | Error differences, lane j against the (j+1)-th older error |
| out_xdiff | output | WIN_LEN×DW | Sample differences, same lane order |
| window_done | output | 1 | Pulse with the last slot's differences |
| ovf_sticky | output | 1 | Sticky flag, set by any clamped difference |

## Verification
The main function is tried with four kinds of input:
- An ascending ramp. Its differences grow with lane index, so this exposes any mix-up of lane order or window age.
- Mixed-sign pseudo-random values. These catch sign-extension and borrow errors that a ramp hides.
- Values near both ends of the signed range. These tell clamping apart from wrap-around, and they show whether the sticky flag follows only valid lanes.
- Streams broken by idle cycles with junk on the data inputs, and back-to-back windows. These show that gaps leave no trace, and that a window boundary and a reset both wipe the history and restart the mask at zero.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
   typedef enum logic {
      OVF_WRAP  = 1'b0,
      OVF_CLAMP = 1'b1
   } ovf_mode_e;
endpackage

// File: rtl/pdw_history.sv
module pdw_history #(
   parameter int WIN_LEN = 8,
   parameter int DW      = 32
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           shift_en,
   input  logic                           clear,
   input  logic [DW-1:0]                  din,
   output logic [WIN_LEN-1:0][DW-1:0]     hist
);
   // hist[0] holds the newest stored value, hist[WIN_LEN-1] the oldest
   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
      end else if (shift_en) begin
         if (clear) hist <= '0;
         else       hist <= {hist[WIN_LEN-2:0], din};
      end
   end
endmodule

// File: rtl/pdw_slot_ctrl.sv
module pdw_slot_ctrl #(
   parameter int WIN_LEN = 8,
   localparam int SLOT_W = $clog2(WIN_LEN)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                advance,
   output logic [SLOT_W-1:0]   slot,
   output logic                last_slot,
   output logic [WIN_LEN-1:0]  lane_mask
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WIN_LEN - 1);

   assign last_slot = (slot == LAST);

   always_ff @(posedge clk) begin
      if (rst)          slot <= '0;
      else if (advance) slot <= last_slot ? '0 : slot + 1'b1;
   end

   // lane j holds a real partner only when j older entries... i.e. j < slot
   for (genvar j = 0; j < WIN_LEN; j++) begin : g_mask
      assign lane_mask[j] = (j < int'(slot));
   end
endmodule

// File: rtl/pdw_lane_sub.sv
module pdw_lane_sub
   import pdw_pkg::*;
#(
   parameter int        DW   = 32,
   parameter ovf_mode_e MODE = OVF_CLAMP
) (
   input  logic [DW-1:0] minuend,
   input  logic [DW-1:0] subtrahend,
   output logic [DW-1:0] diff,
   output logic          ovf
);
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

   logic [DW:0] wide;

   assign wide = {minuend[DW-1], minuend} - {subtrahend[DW-1], subtrahend};
   assign ovf  = wide[DW] ^ wide[DW-1];

   if (MODE == OVF_CLAMP) begin : g_clamp
      always_comb begin
         if (!ovf)          diff = wide[DW-1:0];
         else if (wide[DW]) diff = NEG_MIN;
         else               diff = POS_MAX;
      end
   end else begin : g_wrap
      assign diff = wide[DW-1:0];
   end
endmodule

// File: rtl/pairdiff_window.sv
module pairdiff_window
   import pdw_pkg::*;
#(
   parameter int        WIN_LEN  = 8,
   parameter int        DW       = 32,
   parameter ovf_mode_e OVF_MODE = OVF_CLAMP
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   input  logic [DW-1:0]               in_error,
   input  logic [DW-1:0]               in_x,
   output logic                        out_valid,
   output logic [WIN_LEN-1:0]          out_lane_valid,
   output logic [WIN_LEN-1:0][DW-1:0]  out_ediff,
   output logic [WIN_LEN-1:0][DW-1:0]  out_xdiff,
   output logic                        window_done,
   output logic                        ovf_sticky
);
   localparam int SLOT_W = $clog2(WIN_LEN);

   // R9: elaboration-time parameter checks
   if (WIN_LEN < 2) begin : g_bad_len
      $error("pairdiff_window: WIN_LEN must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("pairdiff_window: DW must be at least 2");
   end

   logic [SLOT_W-1:0]          slot;
   logic                       last_slot;
   logic [WIN_LEN-1:0]         lane_mask;
   logic [WIN_LEN-1:0][DW-1:0] e_hist;
   logic [WIN_LEN-1:0][DW-1:0] x_hist;
   logic [WIN_LEN-1:0][DW-1:0] e_raw;
   logic [WIN_LEN-1:0][DW-1:0] x_raw;
   logic [WIN_LEN-1:0]         e_ovf;
   logic [WIN_LEN-1:0]         x_ovf;
   logic                       any_ovf;

   pdw_slot_ctrl #(.WIN_LEN(WIN_LEN)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .advance   (in_valid),
      .slot      (slot),
      .last_slot (last_slot),
      .lane_mask (lane_mask)
   );

   pdw_history #(.WIN_LEN(WIN_LEN), .DW(DW)) u_ehist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .clear    (last_slot),
      .din      (in_error),
      .hist     (e_hist)
   );

   pdw_history #(.WIN_LEN(WIN_LEN), .DW(DW)) u_xhist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .clear    (last_slot),
      .din      (in_x),
      .hist     (x_hist)
   );

   for (genvar j = 0; j < WIN_LEN; j++) begin : g_lane
      pdw_lane_sub #(.DW(DW), .MODE(OVF_MODE)) u_esub (
         .minuend    (in_error),
         .subtrahend (e_hist[j]),
         .diff       (e_raw[j]),
         .ovf        (e_ovf[j])
      );
      pdw_lane_sub #(.DW(DW), .MODE(OVF_MODE)) u_xsub (
         .minuend    (in_x),
         .subtrahend (x_hist[j]),
         .diff       (x_raw[j]),
         .ovf        (x_ovf[j])
      );
   end

   assign any_ovf = in_valid && (|((e_ovf | x_ovf) & lane_mask));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid      <= 1'b0;
         out_lane_valid <= '0;
         out_ediff      <= '0;
         out_xdiff      <= '0;
         window_done    <= 1'b0;
         ovf_sticky     <= 1'b0;
      end else begin
         out_valid      <= in_valid;
         out_lane_valid <= in_valid ? lane_mask : '0;
         window_done    <= in_valid && last_slot;
         for (int j = 0; j < WIN_LEN; j++) begin
            out_ediff[j] <= (in_valid && lane_mask[j]) ? e_raw[j] : '0;
            out_xdiff[j] <= (in_valid && lane_mask[j]) ? x_raw[j] : '0;
         end
         if (any_ovf) ovf_sticky <= 1'b1;
      end
   end
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker #(
   parameter int WIN_LEN = 8,
   parameter int DW      = 32
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic                        out_valid,
   input logic [WIN_LEN-1:0]          out_lane_valid,
   input logic [WIN_LEN-1:0][DW-1:0]  out_ediff,
   input logic [WIN_LEN-1:0][DW-1:0]  out_xdiff,
   input logic                        window_done,
   input logic                        ovf_sticky
);
   localparam int SLOT_W = $clog2(WIN_LEN);
   logic [SLOT_W-1:0] chk_slot;

   always_ff @(posedge clk) begin
      if (rst) chk_slot <= '0;
      else if (in_valid) chk_slot <= (int'(chk_slot) == WIN_LEN - 1) ? '0 : chk_slot + 1'b1;
   end

   p_mask_count_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid && ($countones(out_lane_valid) == int'($past(chk_slot))));

   p_mask_contig_r2: assert property (@(posedge clk) disable iff (rst)
      ((out_lane_valid + 1'b1) & out_lane_valid) == '0);

   p_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && (out_lane_valid == '0) && !window_done);

   p_done_full_r7: assert property (@(posedge clk) disable iff (rst)
      window_done |-> out_valid && ($countones(out_lane_valid) == WIN_LEN - 1));

   p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      ovf_sticky |=> ovf_sticky);

   for (genvar j = 0; j < WIN_LEN; j++) begin : g_zero
      p_lane_zero_r4: assert property (@(posedge clk) disable iff (rst)
         !out_lane_valid[j] |-> (out_ediff[j] == '0) && (out_xdiff[j] == '0));
   end
endmodule

bind pairdiff_window pdw_checker #(.WIN_LEN(WIN_LEN), .DW(DW)) u_pdw_checker (
   .clk            (clk),
   .rst            (rst),
   .in_valid       (in_valid),
   .out_valid      (out_valid),
   .out_lane_valid (out_lane_valid),
   .out_ediff      (out_ediff),
   .out_xdiff      (out_xdiff),
   .window_done    (window_done),
   .ovf_sticky     (ovf_sticky)
);

// File: tb/tb_pairdiff_window.sv
module tb_pairdiff_window;
   localparam int N  = 8;
   localparam int DW = 32;

   logic                      clk = 1'b0;
   logic                      rst;
   logic                      in_valid;
   logic [DW-1:0]             in_error;
   logic [DW-1:0]             in_x;
   logic                      out_valid;
   logic [N-1:0]              out_lane_valid;
   logic [N-1:0][DW-1:0]      out_ediff;
   logic [N-1:0][DW-1:0]      out_xdiff;
   logic                      window_done;
   logic                      ovf_sticky;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // reference model state
   logic [DW-1:0] m_e [N];
   logic [DW-1:0] m_x [N];
   int            m_cnt = 0;
   bit            m_sticky = 0;

   always #5 clk = ~clk;

   pairdiff_window #(.WIN_LEN(N), .DW(DW)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_error(in_error), .in_x(in_x),
      .out_valid(out_valid), .out_lane_valid(out_lane_valid), .out_ediff(out_ediff),
      .out_xdiff(out_xdiff), .window_done(window_done), .ovf_sticky(ovf_sticky)
   );

   function automatic logic [DW-1:0] ref_sub(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                             output bit clamped);
      longint sa, sb, d;
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      d  = sa - sb;
      clamped = 1'b0;
      if (d > 64'sd2147483647) begin
         clamped = 1'b1;
         return 32'h7FFF_FFFF;
      end
      if (d < -64'sd2147483648) begin
         clamped = 1'b1;
         return 32'h8000_0000;
      end
      return d[DW-1:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_e[i] = '0;
         m_x[i] = '0;
      end
      m_cnt = 0;
   endtask

   // send one pair, compare the outputs one cycle later
   task automatic send(input logic [DW-1:0] e, input logic [DW-1:0] x);
      logic [N-1:0]         exp_mask;
      logic [N-1:0][DW-1:0] exp_e;
      logic [N-1:0][DW-1:0] exp_x;
      bit                   exp_done;
      bit                   c1, c2;
      bit                   e_ok, x_ok;
      exp_mask = '0;
      exp_e = '0;
      exp_x = '0;
      for (int j = 0; j < N; j++) begin
         if (j < m_cnt) begin
            exp_mask[j] = 1'b1;
            exp_e[j] = ref_sub(e, m_e[j], c1);
            exp_x[j] = ref_sub(x, m_x[j], c2);
            if (c1 || c2) m_sticky = 1;
         end
      end
      exp_done = (m_cnt == N - 1);
      @(negedge clk);
      in_valid = 1'b1;
      in_error = e;
      in_x     = x;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R2", "out_valid", out_valid, 1);
      check(out_lane_valid == exp_mask, "R2", "lane mask", out_lane_valid, exp_mask);
      e_ok = 1; x_ok = 1;
      for (int j = 0; j < N; j++) begin
         if (out_ediff[j] != exp_e[j]) begin
            e_ok = 0;
            $display("FAIL R3 ediff lane %0d: actual %0h expected %0h", j, out_ediff[j], exp_e[j]);
         end
         if (out_xdiff[j] != exp_x[j]) begin
            x_ok = 0;
            $display("FAIL R3 xdiff lane %0d: actual %0h expected %0h", j, out_xdiff[j], exp_x[j]);
         end
      end
      checks += 2;
      if (!e_ok) fails++;
      if (!x_ok) fails++;
      check(window_done == exp_done, "R7", "window_done", window_done, exp_done);
      check(ovf_sticky == m_sticky, "R6", "ovf_sticky", ovf_sticky, m_sticky);
      // update model
      if (m_cnt == N - 1) begin
         model_clear();
      end else begin
         for (int i = N - 1; i > 0; i--) begin
            m_e[i] = m_e[i-1];
            m_x[i] = m_x[i-1];
         end
         m_e[0] = e;
         m_x[0] = x;
         m_cnt++;
      end
   endtask

   task automatic idle_cycle(input logic [DW-1:0] junk);
      @(negedge clk);
      in_valid = 1'b0;
      in_error = junk;
      in_x     = ~junk;
      @(posedge clk);
      #1;
      check(!out_valid && out_lane_valid == '0 && !window_done, "R8", "idle outputs",
            {out_valid, window_done, out_lane_valid}, 0);
   endtask

   task automatic align_window();
      while (m_cnt != 0) send(32'd1, 32'd2);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      check(out_valid == 0 && out_lane_valid == 0 && out_ediff == '0 && out_xdiff == '0
            && window_done == 0 && ovf_sticky == 0, "R1", "outputs in reset",
            {out_valid, window_done, ovf_sticky}, 0);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      m_sticky = 0;
      @(posedge clk);
      #1;
      check(out_valid == 0 && out_lane_valid == 0 && ovf_sticky == 0, "R1",
            "outputs after reset", {out_valid, ovf_sticky}, 0);
   endtask

   task automatic t_ramp();  // R2 R3 R7
      for (int i = 0; i < N; i++) send(32'(i * 3 + 5), 32'(100 - i * 7));
      send(32'd40, 32'd41);  // R7: new window, mask empty
   endtask

   task automatic t_mixed();  // R3 R4 signs
      logic [31:0] lfsr = 32'hACE1_2345;
      align_window();
      for (int i = 0; i < 2 * N + 3; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         send({{4{lfsr[31]}}, lfsr[27:0]}, {{6{lfsr[3]}}, lfsr[31:6]});
      end
   endtask

   task automatic t_gaps();  // R8
      align_window();
      send(32'd10, 32'd20);
      idle_cycle(32'hDEAD_BEEF);
      idle_cycle(32'h8000_0001);
      send(32'hFFFF_FFF0, 32'd7);
      idle_cycle(32'h1234_5678);
      send(32'd3, 32'hFFFF_FF00);
   endtask

   task automatic t_sat();  // R5 R6
      align_window();
      check(ovf_sticky == 0, "R6", "flag before clamp", ovf_sticky, 0);
      send(32'h7FFF_FFF0, 32'd0);
      send(32'h8000_0010, 32'd1);  // e lane0 -> clamp at minimum
      send(32'h7FFF_FFFF, 32'd2);  // e lanes -> clamp at maximum
      idle_cycle(32'd0);
      check(ovf_sticky == 1, "R6", "flag held", ovf_sticky, 1);
      align_window();
      send(32'd0, 32'h8000_0000);
      send(32'd0, 32'h7FFF_FFFF);  // x clamp at maximum
   endtask

   task automatic t_reset_mid();  // R1
      align_window();
      send(32'd9, 32'd9);
      send(32'd8, 32'd8);
      send(32'd7, 32'd7);
      do_reset();
      send(32'd6, 32'd6);  // expects empty mask, slot 0
      send(32'd1, 32'd2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      in_valid = 1'b0;
      in_error = '0;
      in_x = '0;
      model_clear();
      do_reset();
      t_ramp();
      t_mixed();
      t_gaps();
      t_sat();
      t_reset_mid();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule